// File: doc/BRIEF.md
# Write-Protected Prescaled Watchdog Timer

This block watches for a stalled program. Software enables it and must then rewrite the enable bit again and again. If it misses a deadline, the block raises either a pulsed system-reset request or a sticky high-priority interrupt request. The deadline is counted in pulses of a slow 32.768 kHz tick-enable input. A 4-bit prescale code selects it, from 2^9 to 2^16 ticks, which is 15.6 ms up to 2 s.

One 8-bit control/status register holds all of the state, and the bus can always read it. Writes to it are guarded. Software first sets the unlock bit, and the very next bus write must target the register. Every other write is dropped. One prescale code forces an immediate reset, and the codes above it never time out. The timeout flag stays set through a watchdog-caused reset, so software can see why the system restarted. Only software or the external hardware reset clears it. A power-supply-monitor event switches the watchdog off.

Top module: `wdt_guard`

## Requirements
- R1: After hardware reset (rst_n low), the register reads 0x10 and both request outputs are low. The register layout is: bits [7:4] prescale code, bit 3 interrupt mode, bit 2 timeout flag, bit 1 enable, bit 0 unlock.
- R2: A write to the register address while unlocked is not in effect leaves bits [7:1] unchanged. It sets the unlock bit when data bit 0 is 1.
- R3: While the unlock bit is set, the next bus write clears it. If that write targets the register address, it loads bits [7:1] from the data. If it targets any other address, the register is otherwise unchanged.
- R4: With the watchdog enabled and prescale code p in 0..7, expiry happens on the 2^(9+p)-th tick_en pulse after the last enabling write. Clock cycles without tick_en do not count.
- R5: An accepted write with data bit 1 set restarts the count from zero.
- R6: On expiry in reset mode (bit 3 = 0), the block sets the flag and clears the enable. rst_req is then high for exactly RST_CYC (default 4) cycles, starting right after the expiring edge.
- R7: On expiry in interrupt mode (bit 3 = 1), the block sets the flag and keeps the enable and the count running. irq_req rises and stays high until the flag is cleared. rst_req stays low.
- R8: The flag is cleared only by an accepted write with data bit 2 = 0, or by hardware reset. Writing 1 to it has no effect, and a watchdog reset leaves it set.
- R9: Prescale code 8 with the enable set fires a reset one cycle after it is loaded, even in interrupt mode. It sets the flag and clears the enable.
- R10: Prescale codes 9 to 15 hold the count, so no timeout ever occurs.
- R11: A supply_evt pulse clears the enable bit.
- R12: With the enable bit clear, tick pulses cause no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous |
| tick_en | input | 1 | Slow-clock enable, one pulse per 32.768 kHz period |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Current control/status register value |
| supply_evt | input | 1 | Power-supply-monitor event pulse |
| rst_req | output | 1 | System-reset request pulse |
| irq_req | output | 1 | High-priority interrupt request |

## Verification
Timing is checked one tick short of the deadline and again on the deadline itself, for codes 0 and 1. A count off by one, or a wrong power of two, shows up on one side of that boundary. Re-enabling mid-period, idle gaps without ticks, and codes 8, 9 and 15 separate a count that restarts, pauses, fires at once or never fires. Write sequences that are unlocked, locked, and redirected to a foreign address test the write guard. Clearing the flag in interrupt mode and in reset mode tests the sticky flag and the interrupt it holds.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Register view; field order matches bit positions 7..0.
  typedef struct packed {
    logic [3:0] pre;
    logic       irq_mode;
    logic       flag;
    logic       en;
    logic       armed;
  } wdt_ctrl_t;

  localparam int DEF_BASE_SHIFT = 9;
  localparam int DEF_MAX_CODE   = 7;
  localparam int DEF_IMM_CODE   = 8;

  // Number of tick pulses in one timeout period for a prescale code.
  function automatic int unsigned ticks_for(input int base, input logic [3:0] code);
    return 32'd1 << (base + int'(code));
  endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_we,
  input  logic addr_hit,
  input  logic d0,
  output logic armed,
  output logic accept
);

  logic arm_n;

  assign accept = bus_we && addr_hit && armed;

  always_comb begin
    arm_n = armed;
    if (bus_we) begin
      arm_n = armed ? 1'b0 : (addr_hit && d0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= arm_n;
  end

  // R3
  arm_single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && armed |=> !armed);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_guard_pkg::*;
#(
  parameter int BASE_SHIFT = DEF_BASE_SHIFT,
  parameter int MAX_CODE   = DEF_MAX_CODE,
  parameter int IMM_CODE   = DEF_IMM_CODE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       kick,
  input  logic [3:0] pre,
  output logic       expire,
  output logic       imm
);

  localparam int CNT_W = BASE_SHIFT + MAX_CODE;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             counting;
  logic             reserved;

  assign counting = int'(pre) <= MAX_CODE;
  assign imm      = run && (int'(pre) == IMM_CODE);
  assign reserved = !counting && (int'(pre) != IMM_CODE);
  assign last_val = CNT_W'(ticks_for(BASE_SHIFT, pre) - 32'd1);
  assign expire   = run && counting && tick && !kick && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || kick || expire) begin
      cnt_q <= '0;
    end else if (tick && counting) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && reserved |=> $stable(cnt_q));

  // R12
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_rst,
  input  logic fire_irq,
  input  logic flag_next,
  output logic rst_req,
  output logic irq_req
);

  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      irq_req <= 1'b0;
    end else begin
      if (fire_rst)           pulse_q <= PW'(RST_CYC);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      irq_req <= fire_irq || (irq_req && flag_next);
    end
  end

  assign rst_req = pulse_q != '0;

  // R6
  rst_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rst |=> rst_req);

  // R7
  irq_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_irq |=> irq_req);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h5C,
  parameter int              BASE_SHIFT = DEF_BASE_SHIFT,
  parameter int              MAX_CODE   = DEF_MAX_CODE,
  parameter int              IMM_CODE   = DEF_IMM_CODE,
  parameter int              RST_CYC    = 4,
  parameter logic [7:0]      RESET_VAL  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              supply_evt,
  output logic              rst_req,
  output logic              irq_req
);

  wdt_ctrl_t reset_view;
  wdt_ctrl_t view;

  logic [3:0] pre_q, pre_n;
  logic       mode_q, mode_n;
  logic       flag_q, flag_n;
  logic       en_q, en_n;

  logic armed, accept, kick, wr_blocked;
  logic expire, imm, fire_rst, fire_irq;

  assign reset_view = wdt_ctrl_t'(RESET_VAL);

  wdt_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .addr_hit (bus_addr == CTRL_ADDR),
    .d0       (bus_wdata[0]),
    .armed    (armed),
    .accept   (accept)
  );

  assign kick       = accept && bus_wdata[1];
  assign wr_blocked = bus_we && !accept;

  wdt_counter #(
    .BASE_SHIFT (BASE_SHIFT),
    .MAX_CODE   (MAX_CODE),
    .IMM_CODE   (IMM_CODE)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_q),
    .tick   (tick_en),
    .kick   (kick),
    .pre    (pre_q),
    .expire (expire),
    .imm    (imm)
  );

  assign fire_rst = imm || (expire && !mode_q);
  assign fire_irq = expire && mode_q && !imm;

  always_comb begin
    pre_n  = pre_q;
    mode_n = mode_q;
    flag_n = flag_q;
    en_n   = en_q;
    if (accept) begin
      pre_n  = bus_wdata[7:4];
      mode_n = bus_wdata[3];
      flag_n = flag_q && bus_wdata[2];
      en_n   = bus_wdata[1];
    end
    if (supply_evt)           en_n   = 1'b0;
    if (fire_rst || fire_irq) flag_n = 1'b1;
    if (fire_rst)             en_n   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= reset_view.pre;
      mode_q <= reset_view.irq_mode;
      flag_q <= reset_view.flag;
      en_q   <= reset_view.en;
    end else begin
      pre_q  <= pre_n;
      mode_q <= mode_n;
      flag_q <= flag_n;
      en_q   <= en_n;
    end
  end

  wdt_response #(.RST_CYC(RST_CYC)) u_response (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_rst  (fire_rst),
    .fire_irq  (fire_irq),
    .flag_next (flag_n),
    .rst_req   (rst_req),
    .irq_req   (irq_req)
  );

  always_comb begin
    view.pre      = pre_q;
    view.irq_mode = mode_q;
    view.flag     = flag_q;
    view.en       = en_q;
    view.armed    = armed;
  end
  assign bus_rdata = view;

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(pre_q) && $stable(mode_q));

  // R9
  imm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm |=> !en_q && flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !accept |=> flag_q);

  // R11
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_evt |=> !en_q);

endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;

  localparam logic [7:0] CTRL = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       supply_evt = 1'b0;
  logic       rst_req;
  logic       irq_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .supply_evt (supply_evt),
    .rst_req    (rst_req),
    .irq_req    (irq_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pwr(input logic [7:0] d);
    wr(CTRL, 8'h01);
    wr(CTRL, d);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    hw_reset();
    chk("R1 reg", bus_rdata, 8'h10);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_unlock();
    hw_reset();
    wr(CTRL, 8'hFA);
    chk("R2 locked write", bus_rdata, 8'h10);
    wr(CTRL, 8'h01);
    chk("R2 arm set", bus_rdata, 8'h11);
    wr(CTRL + 8'h1, 8'h0A);
    chk("R3 foreign write drops arm", bus_rdata, 8'h10);
    wr(CTRL, 8'h0A);
    chk("R2 write after drop", bus_rdata, 8'h10);
    pwr(8'h2B);
    chk("R3 unlocked write", bus_rdata, 8'h2A);
  endtask

  task automatic t_reset_mode();
    int hi = 0;
    hw_reset();
    pwr(8'h02);
    ticks(511);
    chk("R4 p0 before deadline", bus_rdata, 8'h02);
    chk("R6 no rst early", rst_req, 0);
    ticks(1);
    chk("R6 flag set en clear", bus_rdata, 8'h04);
    while (rst_req && hi < 20) begin hi++; @(negedge clk); end
    chk("R6 pulse length", hi, 4);
    chk("R8 flag kept after wd reset", bus_rdata, 8'h04);
    pwr(8'h04);
    chk("R8 writing 1 keeps flag", bus_rdata, 8'h04);
    pwr(8'h00);
    chk("R8 write 0 clears flag", bus_rdata, 8'h00);
  endtask

  task automatic t_irq_mode();
    hw_reset();
    pwr(8'h0A);
    ticks(512);
    chk("R7 irq raised", irq_req, 1);
    chk("R7 no rst", rst_req, 0);
    chk("R7 en kept", bus_rdata, 8'h0E);
    repeat (3) @(negedge clk);
    chk("R7 irq held", irq_req, 1);
    pwr(8'h0E);
    chk("R7 irq held on flag=1 write", irq_req, 1);
    pwr(8'h0A);
    chk("R7 irq cleared", irq_req, 0);
    chk("R8 flag cleared", bus_rdata, 8'h0A);
  endtask

  task automatic t_kick();
    hw_reset();
    pwr(8'h02);
    ticks(400);
    repeat (50) @(negedge clk);
    pwr(8'h02);
    ticks(300);
    repeat (40) @(negedge clk);
    ticks(211);
    chk("R5 kick restarts count", bus_rdata, 8'h02);
    ticks(1);
    chk("R4 idle cycles not counted", bus_rdata, 8'h04);
  endtask

  task automatic t_pre1();
    hw_reset();
    pwr(8'h1A);
    ticks(1023);
    chk("R4 p1 before deadline", irq_req, 0);
    ticks(1);
    chk("R4 p1 at deadline", irq_req, 1);
  endtask

  task automatic t_imm();
    hw_reset();
    pwr(8'h8A);
    chk("R9 loaded", bus_rdata, 8'h8A);
    @(negedge clk);
    chk("R9 reset fired", rst_req, 1);
    chk("R9 no irq", irq_req, 0);
    chk("R9 reg", bus_rdata, 8'h8C);
    hw_reset();
    chk("R8 hw reset clears flag", bus_rdata, 8'h10);
  endtask

  task automatic t_reserved();
    hw_reset();
    pwr(8'h92);
    ticks(2000);
    chk("R10 code 9 no timeout", bus_rdata, 8'h92);
    chk("R10 code 9 no rst", rst_req, 0);
    pwr(8'hFA);
    ticks(1000);
    chk("R10 code 15 no timeout", bus_rdata, 8'hFA);
    chk("R10 code 15 no irq", irq_req, 0);
  endtask

  task automatic t_supply_and_off();
    hw_reset();
    pwr(8'h02);
    ticks(100);
    @(negedge clk); supply_evt = 1'b1;
    @(negedge clk); supply_evt = 1'b0;
    chk("R11 en cleared", bus_rdata, 8'h00);
    ticks(600);
    chk("R12 disabled no timeout", bus_rdata, 8'h00);
    chk("R12 no rst", rst_req, 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_unlock();
    t_reset_mode();
    t_irq_mode();
    t_kick();
    t_pre1();
    t_imm();
    t_reserved();
    t_supply_and_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule